// File: doc/BRIEF.md
# Gated Dual Pulse Counter

This block measures two slow pulse trains over a fixed, repeating gate. One line carries pulses from a voltage-to-frequency temperature converter. Its falling edges advance a 16-bit live count, and the low byte carries into the high byte. The second line is an auxiliary input. Its falling edges advance an 8-bit live count that wraps. Both lines idle high because they are pulled up, and they are asynchronous to the system clock.

A prescaler divides the system clock. Its ticks drive a timer that restarts from a preload value each time it overflows. Each overflow closes a gate. In the same clock edge, both live counts are copied into holding registers and the live counters start again from zero. A one-cycle gate event marks the edge on which the held values change.

The defaults are a 4 MHz clock, a divide-by-64 prescaler and a 16-bit timer preloaded with 0x0BDC. That gives 62500 ticks, or one second per gate. A testbench can shorten the gate by overriding the parameters.

The held values are plain outputs with no handshake. A reader samples them after a gate event, and they keep their value for the whole of the next gate.

Top module: `gated_edge_tally`

## Requirements
- R1: Each falling edge on `vf_pulse` adds one to the live temperature count. A line that stays high or stays low adds nothing. A rising edge adds nothing.
- R2: The temperature count is `TEMP_W` bits wide (16 by default), and its low byte carries into its high byte. For example, 300 edges in one gate are held as 0x012C.
- R3: The auxiliary count is `AUX_W` bits wide (8 by default) and wraps modulo 2^AUX_W. For example, 260 edges in one gate are held as 0x04.
- R4: Gate events repeat every `DIV * (2^TIMER_W - PRELOAD)` clock cycles. The defaults give 4,000,000 cycles, which is one second at 4 MHz.
- R5: At each gate end, both held values take the counts of the interval that just ended, on the same clock edge. Both live counters restart, so every edge is counted in exactly one interval.
- R6: `gate_evt` is high for exactly one cycle per gate. It rises on the same clock edge on which the held values are updated.
- R7: Between gate events, `held_temp`, `held_aux` and `held_word` do not change.
- R8: Each falling edge is counted two clock edges after the first clock edge that samples it low. An edge whose count falls on the snapshot edge goes into the new interval. An edge whose count falls one cycle earlier goes into the interval that is ending.
- R9: `held_word` is laid out in readout order, as {temp high byte, temp low byte, aux}. With the defaults:
  - bits [23:16] hold temp[15:8];
  - bits [15:8] hold temp[7:0];
  - bits [7:0] hold aux.
- R10: While `rst` is high, the held values, the live counts and `gate_evt` are all zero. The sampled lines are taken as high, so idle-high inputs add no count after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vf_pulse | input | 1 | Temperature converter pulse line, asynchronous, idles high |
| aux_pulse | input | 1 | Auxiliary pulse line, asynchronous, idles high |
| held_temp | output | TEMP_W | Temperature count of the last completed gate |
| held_aux | output | AUX_W | Auxiliary count of the last completed gate |
| held_word | output | TEMP_W+AUX_W | {held_temp, held_aux} in readout order |
| gate_evt | output | 1 | One-cycle pulse on the edge the held values change |

## Verification
The bench drives the following patterns, one per gate:
- A quiet gate.
- A small count on both lines.
- 300 temperature edges, which checks the carry from the low byte into the high byte.
- 260 auxiliary edges, which checks the wrap.
- Equal bursts on both lines at once, which shows whether the two channels interfere.

One gate places a temperature edge so that it is counted one cycle before the snapshot, and an auxiliary edge so that it is counted exactly on the snapshot. This separates the old interval from the new one. The bench also measures the spacing between gate events, the width of each event pulse, and whether the held values stay still between events.

// File: rtl/gtally_pkg.sv
package gtally_pkg;

  // Number of clock cycles in one gate, from the prescale divide, the timer width and the preload.
  function automatic int unsigned gate_len(input int unsigned div,
                                           input int unsigned tw,
                                           input int unsigned preload);
    return div * ((32'd1 << tw) - preload);
  endfunction

endpackage

// File: rtl/edge_sync_fall.sv
module edge_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall_o
);
  // chain[0 .. STAGES-1] is the synchronizer; chain[STAGES] is the copy delayed by one more cycle
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;  // idle-high line: no false edge after reset
    else     chain <= {chain[STAGES-1:0], pin};
  end

  assign fall_o = chain[STAGES] & ~chain[STAGES-1];

  // R1
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/gate_timer.sv
module gate_timer #(
  parameter int          DIV     = 64,
  parameter int          TW      = 16,
  parameter int unsigned PRELOAD = 32'h0BDC
) (
  input  logic clk,
  input  logic rst,
  output logic gate_end_o
);
  localparam int          DW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned PERIOD = gtally_pkg::gate_len(DIV, TW, PRELOAD);

  logic [DW-1:0] pre_q;
  logic [TW-1:0] tmr_q;
  logic          tick;

  assign tick = (pre_q == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                tmr_q <= TW'(PRELOAD);
    else if (tick) begin
      if (tmr_q == '1)      tmr_q <= TW'(PRELOAD);
      else                  tmr_q <= tmr_q + 1'b1;
    end
  end

  assign gate_end_o = tick && (tmr_q == '1);

  // Checker: counts cycles since the last gate end
  logic [31:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)             gap_q <= '0;
    else if (gate_end_o) gap_q <= '0;
    else                 gap_q <= gap_q + 1'b1;
  end

  // R4
  gate_period_chk: assert property (@(posedge clk) disable iff (rst)
    gate_end_o |-> (gap_q == PERIOD - 1));
  // R4
  gate_bound_chk: assert property (@(posedge clk) disable iff (rst)
    gap_q < PERIOD);
endmodule

// File: rtl/tally_counter.sv
module tally_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         edge_i,
  input  logic         snap_i,
  output logic [W-1:0] held_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      held_o <= '0;
    end else if (snap_i) begin
      held_o <= cnt_q;
      cnt_q  <= edge_i ? W'(1) : '0;  // an edge on the snapshot edge opens the new interval
    end else if (edge_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R8
  carry_in_chk: assert property (@(posedge clk) disable iff (rst)
    (snap_i && edge_i) |=> (cnt_q == W'(1)));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (snap_i && !edge_i) |=> (cnt_q == '0));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!snap_i && edge_i && cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/gated_edge_tally.sv
module gated_edge_tally #(
  parameter int          DIV         = 64,
  parameter int          TIMER_W     = 16,
  parameter int unsigned PRELOAD     = 32'h0BDC,
  parameter int          TEMP_W      = 16,
  parameter int          AUX_W       = 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vf_pulse,
  input  logic                    aux_pulse,
  output logic [TEMP_W-1:0]       held_temp,
  output logic [AUX_W-1:0]        held_aux,
  output logic [TEMP_W+AUX_W-1:0] held_word,
  output logic                    gate_evt
);
  logic vf_fall, aux_fall, gate_end;

  edge_sync_fall #(.STAGES(SYNC_STAGES)) u_vf_sync (
    .clk(clk), .rst(rst), .pin(vf_pulse), .fall_o(vf_fall));

  edge_sync_fall #(.STAGES(SYNC_STAGES)) u_aux_sync (
    .clk(clk), .rst(rst), .pin(aux_pulse), .fall_o(aux_fall));

  gate_timer #(.DIV(DIV), .TW(TIMER_W), .PRELOAD(PRELOAD)) u_gate (
    .clk(clk), .rst(rst), .gate_end_o(gate_end));

  tally_counter #(.W(TEMP_W)) u_temp_cnt (
    .clk(clk), .rst(rst), .edge_i(vf_fall), .snap_i(gate_end), .held_o(held_temp));

  tally_counter #(.W(AUX_W)) u_aux_cnt (
    .clk(clk), .rst(rst), .edge_i(aux_fall), .snap_i(gate_end), .held_o(held_aux));

  always_ff @(posedge clk) begin
    if (rst) gate_evt <= 1'b0;
    else     gate_evt <= gate_end;
  end

  assign held_word = {held_temp, held_aux};

  // R7
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_evt |-> $stable(held_word));
  // R6
  evt_source_chk: assert property (@(posedge clk) disable iff (rst)
    gate_evt |-> $past(gate_end));
endmodule

// File: tb/sim_gated_edge_tally.sv
module sim_gated_edge_tally;
  localparam int          CLK_PERIOD = 10;
  localparam int          DIV        = 4;
  localparam int          TW         = 16;
  localparam int unsigned PRELOAD    = 32'hFC00;
  localparam int          G          = DIV * ((1 << TW) - int'(PRELOAD)); // 4096

  logic        clk = 1'b0;
  logic        rst;
  logic        vf_pulse, aux_pulse;
  logic [15:0] held_temp;
  logic [7:0]  held_aux;
  logic [23:0] held_word;
  logic        gate_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_edge_tally #(.DIV(DIV), .TIMER_W(TW), .PRELOAD(PRELOAD),
                     .TEMP_W(16), .AUX_W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .vf_pulse(vf_pulse), .aux_pulse(aux_pulse),
    .held_temp(held_temp), .held_aux(held_aux), .held_word(held_word),
    .gate_evt(gate_evt));

  typedef struct { int t; int a; } exp_t;
  exp_t sb_q[$];

  int errs = 0, checks = 0;
  bit mon_en = 0, done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic push_exp(input int t, input int a);
    exp_t e;
    e.t = t & 16'hFFFF;
    e.a = a & 8'hFF;
    sb_q.push_back(e);
  endtask

  task automatic wait_evt();
    do @(negedge clk); while (gate_evt !== 1'b1);
  endtask

  task automatic drive_vf(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) vf_pulse = 1'b0;
      @(negedge clk);
      @(negedge clk) vf_pulse = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic drive_aux(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) aux_pulse = 1'b0;
      @(negedge clk);
      @(negedge clk) aux_pulse = 1'b1;
      @(negedge clk);
    end
  endtask

  // Monitor: pops the scoreboard on every gate event
  initial begin
    logic [23:0] last_word;
    int gap, ngates;
    bit prev_evt, stable_ok;
    exp_t e;
    last_word = '0; gap = 0; ngates = 0; prev_evt = 0; stable_ok = 1;
    wait (mon_en);
    forever begin
      @(negedge clk);
      if (gate_evt) begin
        chk(!prev_evt, "R6", "event pulse width", 1, 0);
        if (ngates > 0) chk(gap + 1 == G, "R4", "gate spacing", gap + 1, G);
        chk(stable_ok, "R7", "held values still between events", 0, 1);
        if (sb_q.size() == 0) begin
          chk(0, "R5", "unexpected gate, queue empty", held_word, 0);
        end else begin
          e = sb_q.pop_front();
          chk(held_temp == e.t[15:0], "R5", "held temp", held_temp, e.t);
          chk(held_aux == e.a[7:0], "R5", "held aux", held_aux, e.a);
          chk(held_word == {e.t[15:8], e.t[7:0], e.a[7:0]}, "R9", "readout word",
              held_word, {e.t[15:0], e.a[7:0]});
        end
        last_word = held_word; gap = 0; ngates++; prev_evt = 1; stable_ok = 1;
      end else begin
        if (held_word !== last_word) stable_ok = 0;
        gap++; prev_evt = 0;
      end
    end
  end

  // Driver
  initial begin
    rst = 1'b1; vf_pulse = 1'b1; aux_pulse = 1'b1;
    repeat (4) @(negedge clk);
    chk(held_word == '0, "R10", "held word in reset", held_word, 0);
    chk(gate_evt == 1'b0, "R10", "event in reset", gate_evt, 0);
    rst = 1'b0;
    mon_en = 1;
    push_exp(0, 0);                       // R10: idle lines, quiet first gate

    wait_evt();
    fork drive_vf(3); drive_aux(7); join  // R1 small counts
    push_exp(3, 7);

    wait_evt();
    fork drive_vf(300); drive_aux(2); join // R2 carry into high byte: 0x012C
    push_exp(300, 2);

    wait_evt();
    fork drive_vf(1); drive_aux(260); join // R3 wrap: 260 -> 0x04
    push_exp(1, 260);

    wait_evt();
    fork drive_vf(70); drive_aux(70); join // R1 both channels at once
    push_exp(70, 70);

    // R8 boundary: temp counted one cycle before the snapshot, aux on the snapshot
    wait_evt();
    repeat (G - 4) @(negedge clk);
    vf_pulse = 1'b0;
    @(negedge clk);
    aux_pulse = 1'b0;
    push_exp(1, 0);
    repeat (3) @(negedge clk);
    vf_pulse = 1'b1; aux_pulse = 1'b1;
    repeat (2) @(negedge clk);
    fork drive_vf(5); drive_aux(3); join
    push_exp(5, 4);                       // R8: carried-in aux edge plus three more

    wait_evt();
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R5", "every expected gate seen", sb_q.size(), 0);
    chk(gate_evt == 1'b0, "R6", "event low after pulse", gate_evt, 0);
    done = 1;
    report();
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end
endmodule